// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers the data bytes of one page-program operation in a small page latch. When the host asks it to commit, it waits for a fixed self-timed interval and then copies the received bytes into a byte-wide memory array. The copy goes through a synchronous write port, one latch slot per clock. A busy flag covers the whole operation, from the clock after the commit to the last array write. When the operation ends, a one-cycle pulse tells the surrounding logic to clear its write-enable latch.

An operation opens with `start_i`, which carries the target address. Each strobe on `byte_vld_i` then stores one byte at the next location of the same page. Past the last location of the page, the location wraps to the first one. A later byte overwrites an earlier byte that landed on the same location. Serial decoding and protection checks happen outside this block. The protection result arrives on `veto_i` and can reject a commit.

Top module: `page_commit_buf`

## Requirements
- R1: While reset is asserted and right after it, `busy_o`, `arr_we_o` and `wel_clr_o` are all 0.
- R2: After a start at address A, the k-th received byte (k counted from 0) is written to the array at page base of A plus ((offset of A + k) mod PAGE_BYTES). The page base is A with its low log2(PAGE_BYTES) bits cleared, and the offset is those low bits.
- R3: Bytes that run past the end of the page wrap to the first location of the same page. When two bytes land on the same location, the later byte is the one that reaches the array.
- R4: Array locations for which no byte was received keep their previous contents, both inside the committed page and outside it.
- R5: An accepted commit raises `busy_o` in the next cycle. `busy_o` then stays high for exactly CYCLE_CLKS + PAGE_BYTES cycles. No array write happens during its first CYCLE_CLKS cycles.
- R6: A commit starts nothing when no byte has been received since the last start, or when no start came first. In that case `busy_o` stays 0 and nothing is written to the array.
- R7: A commit presented with `veto_i` = 1 starts nothing, writes nothing, and discards the collected bytes.
- R8: While `busy_o` is high, `start_i`, `byte_vld_i` and `commit_i` have no effect. The running operation writes only its own bytes, and no further operation follows it.
- R9: `wel_clr_o` is a single-cycle pulse. It appears in the cycle in which `busy_o` has just fallen, and only at the end of an operation that was started.
- R10: Every array write of one operation addresses the page selected by its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new page operation, sampled with `start_addr_i` |
| start_addr_i | input | ADDR_W | First byte address of the operation |
| byte_vld_i | input | 1 | One data byte is present on `byte_i` |
| byte_i | input | DATA_W | Data byte |
| commit_i | input | 1 | Request to program the collected bytes |
| veto_i | input | 1 | Protection verdict, 1 rejects the commit in the same cycle |
| arr_we_o | output | 1 | Array write enable |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Write in progress |
| wel_clr_o | output | 1 | One-cycle pulse at the end of an operation, clears the write-enable latch |

## Verification
The hardest case to reach from the ports is host traffic that arrives while a program cycle is running. The block must stay deaf to that traffic and must neither start a second operation nor change the latch contents. The stimulus reaches it by injecting a start into a different page, a new data byte and a second commit, all inside the self-timed wait. Afterwards the bench compares the whole array with its own model and watches `busy_o` stay low once the first operation ends. A page overrun longer than the page size exercises overwrite-on-wrap, because one slot then receives two bytes and only the later one may reach the array.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  // Control phases of the page buffer.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // no operation open
    ST_FILL = 2'd1,  // collecting bytes after a start
    ST_WAIT = 2'd2,  // self-timed delay running
    ST_PROG = 2'd3   // latch slots copied into the array
  } pcb_state_e;

endpackage

// File: rtl/pcb_latch.sv
module pcb_latch #(
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8,
  parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_vld_o,
  output logic              any_o
);

  logic [DATA_W-1:0]     slot_data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] slot_vld;

  // One storage slot per page location, each with its own valid flag.
  generate
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      logic [DATA_W-1:0] d_q;
      logic              v_q;
      logic              hit;

      assign hit = wr_i && (wr_off_i == OFF_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_q <= '0;
          v_q <= 1'b0;
        end else if (clr_i) begin
          v_q <= 1'b0;
        end else if (hit) begin
          d_q <= wr_data_i;
          v_q <= 1'b1;
        end
      end

      assign slot_data[g] = d_q;
      assign slot_vld[g]  = v_q;
    end
  endgenerate

  assign rd_data_o = slot_data[rd_off_i];
  assign rd_vld_o  = slot_vld[rd_off_i];
  assign any_o     = |slot_vld;

endmodule

// File: rtl/pcb_timer.sv
module pcb_timer #(
  parameter int CYCLE_CLKS = 64,
  parameter int CNT_W      = $clog2(CYCLE_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic done_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == LAST) begin
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // High in the last cycle of the delay window.
  assign done_o = run_q && (cnt_q == LAST);

endmodule

// File: rtl/pcb_seq.sv
module pcb_seq
  import pcb_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             byte_vld_i,
  input  logic             commit_i,
  input  logic             veto_i,
  input  logic             any_i,
  input  logic             tmr_done_i,
  output logic             cap_o,
  output logic             latch_wr_o,
  output logic             latch_clr_o,
  output logic             tmr_load_o,
  output logic             reject_o,
  output logic             prog_o,
  output logic [OFF_W-1:0] scan_off_o,
  output logic             busy_o,
  output logic             wel_clr_o
);

  localparam logic [OFF_W-1:0] SCAN_LAST = OFF_W'(PAGE_BYTES - 1);

  pcb_state_e       state_q, state_d;
  logic [OFF_W-1:0] scan_q, scan_d;
  logic             done_q, done_d;

  always_comb begin
    state_d     = state_q;
    scan_d      = scan_q;
    done_d      = 1'b0;
    cap_o       = 1'b0;
    latch_wr_o  = 1'b0;
    latch_clr_o = 1'b0;
    tmr_load_o  = 1'b0;
    reject_o    = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_FILL: begin
        if (start_i) begin
          state_d     = ST_FILL;
          cap_o       = 1'b1;
          latch_clr_o = 1'b1;
        end else if (state_q == ST_FILL && byte_vld_i) begin
          latch_wr_o = 1'b1;
        end else if (state_q == ST_FILL && commit_i) begin
          if (any_i && !veto_i) begin
            state_d    = ST_WAIT;
            tmr_load_o = 1'b1;
          end else begin
            state_d     = ST_IDLE;
            latch_clr_o = 1'b1;
            reject_o    = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (tmr_done_i) begin
          state_d = ST_PROG;
          scan_d  = '0;
        end
      end
      ST_PROG: begin
        scan_d = scan_q + 1'b1;
        if (scan_q == SCAN_LAST) begin
          state_d     = ST_IDLE;
          latch_clr_o = 1'b1;
          done_d      = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      scan_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      scan_q  <= scan_d;
      done_q  <= done_d;
    end
  end

  assign prog_o     = (state_q == ST_PROG);
  assign busy_o     = (state_q == ST_WAIT) || (state_q == ST_PROG);
  assign scan_off_o = scan_q;
  assign wel_clr_o  = done_q;

endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              commit_i,
  input  logic              veto_i,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_data_o,
  output logic              busy_o,
  output logic              wel_clr_o
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(PAGE_BYTES - 1);

  // Address arithmetic of the page buffer.
  function automatic logic [ADDR_W-1:0] page_base(input logic [ADDR_W-1:0] a);
    return a & ~OFF_MASK;
  endfunction

  function automatic logic [OFF_W-1:0] page_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [OFF_W-1:0] next_off(input logic [OFF_W-1:0] o);
    return (o == OFF_W'(PAGE_BYTES - 1)) ? '0 : o + 1'b1;
  endfunction

  // Named internal events.
  logic              ev_capture;
  logic              ev_byte;
  logic              ev_clear;
  logic              ev_accept;
  logic              ev_reject;
  logic              ev_tmr_done;
  logic              prog;
  logic              latch_any;
  logic              slot_vld;
  logic [DATA_W-1:0] slot_data;
  logic [OFF_W-1:0]  scan_off;

  logic [ADDR_W-1:0] base_q;
  logic [OFF_W-1:0]  ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else if (ev_capture) begin
      base_q <= page_base(start_addr_i);
      ptr_q  <= page_off(start_addr_i);
    end else if (ev_byte) begin
      ptr_q  <= next_off(ptr_q);
    end
  end

  pcb_seq #(
    .PAGE_BYTES (PAGE_BYTES),
    .OFF_W      (OFF_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .byte_vld_i  (byte_vld_i),
    .commit_i    (commit_i),
    .veto_i      (veto_i),
    .any_i       (latch_any),
    .tmr_done_i  (ev_tmr_done),
    .cap_o       (ev_capture),
    .latch_wr_o  (ev_byte),
    .latch_clr_o (ev_clear),
    .tmr_load_o  (ev_accept),
    .reject_o    (ev_reject),
    .prog_o      (prog),
    .scan_off_o  (scan_off),
    .busy_o      (busy_o),
    .wel_clr_o   (wel_clr_o)
  );

  pcb_latch #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W),
    .OFF_W      (OFF_W)
  ) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (ev_clear),
    .wr_i      (ev_byte),
    .wr_off_i  (ptr_q),
    .wr_data_i (byte_i),
    .rd_off_i  (scan_off),
    .rd_data_o (slot_data),
    .rd_vld_o  (slot_vld),
    .any_o     (latch_any)
  );

  pcb_timer #(
    .CYCLE_CLKS (CYCLE_CLKS)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (ev_accept),
    .done_o (ev_tmr_done)
  );

  // Only slots that received a byte are copied into the array.
  assign arr_we_o   = prog && slot_vld;
  assign arr_addr_o = base_q | ADDR_W'(scan_off);
  assign arr_data_o = slot_data;

endmodule

// File: rtl/pcb_chk.sv
module pcb_chk #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit_i,
  input logic              veto_i,
  input logic              arr_we_o,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic              busy_o,
  input logic              wel_clr_o,
  input logic              ev_accept,
  input logic              ev_reject
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int LEN   = CYCLE_CLKS + PAGE_BYTES;
  localparam int CW    = $clog2(LEN + 2) + 1;

  // Cycles spent busy so far; zero while idle.
  logic [CW-1:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (!busy_o && !arr_we_o && !wel_clr_o);
    end
  end

  assert_we_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> busy_o);

  assert_no_early_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we_o |-> (busy_cnt >= CW'(CYCLE_CLKS)));

  assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_cnt == CW'(LEN)));

  assert_accept_raises_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy_o);

  assert_busy_needs_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(ev_accept && commit_i));

  assert_veto_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && veto_i && !busy_o) |=> !busy_o);

  assert_reject_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> !busy_o);

  assert_clr_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr_o |-> $fell(busy_o));

  assert_clr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr_o |=> !wel_clr_o);

  assert_same_page_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we_o && $past(arr_we_o)) |->
      (arr_addr_o[ADDR_W-1:OFF_W] == $past(arr_addr_o[ADDR_W-1:OFF_W])));

endmodule

bind page_commit_buf pcb_chk #(
  .ADDR_W     (ADDR_W),
  .PAGE_BYTES (PAGE_BYTES),
  .CYCLE_CLKS (CYCLE_CLKS)
) u_pcb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .commit_i   (commit_i),
  .veto_i     (veto_i),
  .arr_we_o   (arr_we_o),
  .arr_addr_o (arr_addr_o),
  .busy_o     (busy_o),
  .wel_clr_o  (wel_clr_o),
  .ev_accept  (ev_accept),
  .ev_reject  (ev_reject)
);

// File: tb/test_page_commit_buf.sv
module test_page_commit_buf;

  localparam int AW    = 8;
  localparam int DW    = 8;
  localparam int PB    = 16;
  localparam int CC    = 24;
  localparam int DEPTH = 1 << AW;
  localparam int NV    = 8;

  // Vector fields: {veto, seed, byte count, start address}
  localparam logic [31:0] VEC [NV] = '{
    {8'h00, 8'h11, 8'd1,  8'h20},  // single byte          R2
    {8'h00, 8'h40, 8'd4,  8'h35},  // mid page             R2
    {8'h00, 8'h60, 8'd5,  8'h4E},  // wraps past end       R3
    {8'h00, 8'h80, 8'd20, 8'h73},  // overruns a full page R3
    {8'h00, 8'h00, 8'd0,  8'h90},  // no data              R6
    {8'h01, 8'hC0, 8'd3,  8'hA2},  // vetoed               R7
    {8'h00, 8'h01, 8'd16, 8'hF0},  // full top page        R2
    {8'h00, 8'h33, 8'd2,  8'h05}   // partial page         R4
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic          byte_vld_i = 1'b0;
  logic [DW-1:0] byte_i = '0;
  logic          commit_i = 1'b0;
  logic          veto_i = 1'b0;
  logic          arr_we_o;
  logic [AW-1:0] arr_addr_o;
  logic [DW-1:0] arr_data_o;
  logic          busy_o;
  logic          wel_clr_o;

  always #2 clk = ~clk;

  page_commit_buf #(
    .ADDR_W     (AW),
    .DATA_W     (DW),
    .PAGE_BYTES (PB),
    .CYCLE_CLKS (CC)
  ) i_page_commit_buf (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .byte_vld_i   (byte_vld_i),
    .byte_i       (byte_i),
    .commit_i     (commit_i),
    .veto_i       (veto_i),
    .arr_we_o     (arr_we_o),
    .arr_addr_o   (arr_addr_o),
    .arr_data_o   (arr_data_o),
    .busy_o       (busy_o),
    .wel_clr_o    (wel_clr_o)
  );

  // The array behind the write port, and the bench's own expectation of it.
  logic [DW-1:0] arr_mem [DEPTH];
  logic [DW-1:0] ref_mem [DEPTH];

  always @(posedge clk) begin
    if (arr_we_o) arr_mem[arr_addr_o] <= arr_data_o;
  end

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_mem(input string req);
    int at = -1;
    for (int i = 0; i < DEPTH; i++) begin
      if (at < 0 && arr_mem[i] !== ref_mem[i]) at = i;
    end
    if (at < 0) check(1'b1, req, 0, 0);
    else check(1'b0, {req, " array content"}, int'(arr_mem[at]), int'(ref_mem[at]));
  endtask

  task automatic do_start(input logic [AW-1:0] a);
    start_i = 1'b1; start_addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_byte(input logic [DW-1:0] d);
    byte_vld_i = 1'b1; byte_i = d;
    @(negedge clk);
    byte_vld_i = 1'b0;
  endtask

  // Drives the commit, then watches the operation cycle by cycle.
  task automatic do_commit(input bit veto, input bit go, input logic [AW-1:0] base,
                           input bit inject, input string req);
    int busy_n = 0;
    int first_we = -1;
    int clr_n = 0;
    int off_page = 0;
    commit_i = 1'b1; veto_i = veto;
    @(negedge clk);
    commit_i = 1'b0; veto_i = 1'b0;
    for (int j = 0; j < CC + PB + 8; j++) begin
      if (busy_o) busy_n++;
      if (arr_we_o && first_we < 0) first_we = j;
      if (arr_we_o && ((arr_addr_o & ~AW'(PB - 1)) != base)) off_page++;
      if (wel_clr_o) clr_n++;
      if (inject) begin
        start_i      = (j == 2);
        start_addr_i = 8'h60;
        byte_vld_i   = (j == 3);
        byte_i       = 8'hEE;
        commit_i     = (j == 4);
      end
      @(negedge clk);
    end
    check(busy_n == (go ? CC + PB : 0), {req, " busy length (R5)"}, busy_n, go ? CC + PB : 0);
    check(clr_n == (go ? 1 : 0), {req, " latch clear pulses (R9)"}, clr_n, go ? 1 : 0);
    if (go) check(first_we >= CC, {req, " first write after delay (R5)"}, first_we, CC);
    check(off_page == 0, {req, " writes outside page (R10)"}, off_page, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      arr_mem[i] = DW'(i) ^ 8'h5A;
      ref_mem[i] = DW'(i) ^ 8'h5A;
    end
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy_o, "R1 busy in reset", busy_o, 0);
    check(!arr_we_o, "R1 write in reset", arr_we_o, 0);
    check(!wel_clr_o, "R1 clear pulse in reset", wel_clr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !arr_we_o && !wel_clr_o, "R1 idle after reset", busy_o, 0);

    // Table of vectors, one page operation each.
    for (int v = 0; v < NV; v++) begin
      logic [AW-1:0] a;
      int nb;
      logic [DW-1:0] seed;
      bit veto;
      bit go;
      logic [AW-1:0] base;
      int off;
      string req;
      a    = VEC[v][7:0];
      nb   = int'(VEC[v][15:8]);
      seed = VEC[v][23:16];
      veto = VEC[v][24];
      base = a & ~AW'(PB - 1);
      off  = int'(a) % PB;
      go   = (nb > 0) && !veto;
      if (nb == 0)            req = "R6";
      else if (veto)          req = "R7";
      else if (off + nb > PB) req = "R3";
      else                    req = "R2";
      do_start(a);
      for (int k = 0; k < nb; k++) begin
        do_byte(seed + DW'(k));
        if (go) ref_mem[base + AW'((off + k) % PB)] = seed + DW'(k);
      end
      do_commit(veto, go, base, 1'b0, req);
      cmp_mem({req, "/R4"});
    end

    // R8: traffic during the running operation is ignored.
    do_start(8'h50);
    do_byte(8'hD0);
    do_byte(8'hD1);
    ref_mem[8'h50] = 8'hD0;
    ref_mem[8'h51] = 8'hD1;
    do_commit(1'b0, 1'b1, 8'h50, 1'b1, "R8");
    start_i = 1'b0; byte_vld_i = 1'b0; commit_i = 1'b0;
    begin
      int late_busy = 0;
      for (int j = 0; j < 12; j++) begin
        if (busy_o) late_busy++;
        @(negedge clk);
      end
      check(late_busy == 0, "R8 no second operation", late_busy, 0);
    end
    cmp_mem("R8/R4");

    // R6: data and commit with no start at all.
    do_byte(8'h77);
    do_commit(1'b0, 1'b0, 8'h00, 1'b0, "R6 no start");
    cmp_mem("R6 no start/R4");

    // R7: after a veto the discarded bytes cannot be committed later.
    do_start(8'hC4);
    do_byte(8'h99);
    do_commit(1'b1, 1'b0, 8'hC0, 1'b0, "R7 veto");
    do_commit(1'b0, 1'b0, 8'hC0, 1'b0, "R7 retry");
    cmp_mem("R7/R4");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule